// File: doc/BRIEF.md
# Delay-Locked Multiplier Phase-Tracking Controller

This block is the digital controller of an all-digital multiplying delay-locked loop. It runs once per reference cycle and owns a 10-bit delay control word. The upper four bits select whole delay units. The lower six bits are a fraction, and a delta-sigma modulator turns that fraction into a small signed dither added to the integer part. The integer plus dither is decoded into a thermometer select for the delay cells.

After reset the controller runs a fixed three-phase sequence. First comes a coarse phase of fixed length, in which signed phase-error samples from a time-to-digital converter are added to the word. Next comes bang-bang tracking with the modulator held off, so the word moves by one step per cycle and the residual error shrinks quickly. The third phase starts once the early/late decisions have alternated for a set number of consecutive cycles, which shows the loop is hovering around lock. From then on the second-order modulator dithers the fraction and the lock flag is raised. A separate 6-bit frequency setting is clamped into the legal divide-ratio range and presented to the feedback divider.

Top module: `dll_track_ctrl`

## Requirements
- R1: While reset is asserted, tdc_en is 1, locked is 0, ctrl_word is 512 and dith_code is 0.
- R2: In the coarse phase, each cycle with tdc_vld high adds the signed two's-complement tdc_err to ctrl_word. Cycles with tdc_vld low leave the word unchanged.
- R3: The coarse phase lasts exactly 10 reference cycles after reset and never returns. After it ends, tdc_en is 0 and tdc_vld/tdc_err have no effect on ctrl_word.
- R4: After the coarse phase, each cycle adds 1 to ctrl_word when bb_up is 1 and subtracts 1 when bb_up is 0.
- R5: ctrl_word saturates at 0 and 1023 in every phase and never wraps.
- R6: Until the dither phase starts, dith_code is 0 and the number of ones in therm equals ctrl_word[9:6].
- R7: The dither phase and locked=1 begin on the cycle that sees the 4th consecutive change of bb_up, counted from the first tracking cycle. A cycle without a change resets the count. locked then stays 1 until reset. With bb_up alternating from the start of tracking, lock is reached within 40 cycles of reset.
- R8: In the dither phase, each cycle takes f = ctrl_word[5:0] before its update and computes s1 = a1+f, c1 = s1>=64, a1 = s1 mod 64, s2 = a2+a1, c2 = s2>=64, a2 = s2 mod 64. It then outputs dith_code = c1+c2-c2_prev as 3-bit two's complement, and c2_prev takes the value c2. a1, a2 and c2_prev are 0 when the phase begins.
- R9: therm is a 15-bit thermometer whose ones fill the low bits. Its count of ones is ctrl_word[9:6]+dith_code, clamped to 0..15.
- R10: n_div equals freq_sel when freq_sel is within 24..47, is 24 below that range and is 47 above it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Reference-cycle clock |
| rst_n | input | 1 | Active-low synchronous reset |
| freq_sel | input | 6 | Requested divide ratio |
| tdc_vld | input | 1 | Phase-error sample valid |
| tdc_err | input | 10 | Signed phase error from the converter |
| bb_up | input | 1 | Early/late decision: 1 raises the word, 0 lowers it |
| ctrl_word | output | 10 | Delay control word |
| therm | output | 15 | Thermometer select for the delay units |
| dith_code | output | 3 | Signed modulator dither |
| tdc_en | output | 1 | Converter enable, high during the coarse phase |
| n_div | output | 6 | Clamped divide ratio |
| locked | output | 1 | Dither phase reached |

## Verification
The coarse phase is driven from a vector table. The table mixes valid and idle samples, positive and negative errors, and sums that overshoot both limits, which separates correct addition from wrapping or from ignoring tdc_vld. Bang-bang tracking first runs a steady run of raises and then a broken alternation, so a design that counts alternations non-consecutively locks too early and fails. The dither phase is compared cycle by cycle against an independent model of the modulator over long alternating and saturating runs. This separates a first-order or mistimed modulator from a correct one, and it also checks the clamping at the top of the thermometer. Out-of-range frequency settings at both ends test the clamp.

// File: rtl/dtc_pkg.sv
package dtc_pkg;
   typedef enum logic [1:0] {
      MD_TDC = 2'd0,
      MD_BB  = 2'd1,
      MD_DSM = 2'd2
   } trk_mode_t;
endpackage

// File: rtl/dtc_mode_seq.sv
module dtc_mode_seq
   import dtc_pkg::*;
#(
   parameter int TDC_CYC = 10,
   parameter int ALT_RUN = 4
) (
   input  logic      clk,
   input  logic      rst_n,
   input  logic      bb_up,
   output trk_mode_t mode,
   output logic      tdc_en,
   output logic      dsm_en,
   output logic      lock
);
   localparam int TW = $clog2(TDC_CYC + 1);
   localparam int AW = $clog2(ALT_RUN + 1);

   logic [TW-1:0] tcnt;
   logic [AW-1:0] acnt;
   logic          seen;
   logic          prev;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         mode <= MD_TDC;
         tcnt <= '0;
         acnt <= '0;
         seen <= 1'b0;
         prev <= 1'b0;
      end else begin
         case (mode)
            MD_TDC: begin
               if (tcnt == TW'(TDC_CYC - 1)) mode <= MD_BB;
               else tcnt <= tcnt + TW'(1);
            end
            MD_BB: begin
               seen <= 1'b1;
               prev <= bb_up;
               if (seen && (bb_up != prev)) begin
                  if (acnt == AW'(ALT_RUN - 1)) mode <= MD_DSM;
                  acnt <= acnt + AW'(1);
               end else begin
                  acnt <= '0;
               end
            end
            default: mode <= MD_DSM;
         endcase
      end
   end

   assign tdc_en = (mode == MD_TDC);
   assign dsm_en = (mode == MD_DSM);
   assign lock   = dsm_en;

   // R3
   tdc_once_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (mode != MD_TDC) |=> (mode != MD_TDC));
   // R7
   lock_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      lock |=> lock);
endmodule

// File: rtl/dtc_word.sv
module dtc_word
   import dtc_pkg::*;
#(
   parameter int CW = 10,
   parameter int EW = 10
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  trk_mode_t            mode,
   input  logic                 tdc_vld,
   input  logic signed [EW-1:0] tdc_err,
   input  logic                 bb_up,
   output logic [CW-1:0]        word
);
   localparam int MAXW = 2**CW - 1;
   localparam int MIDW = 2**(CW - 1);

   logic signed [CW+1:0] cur;
   logic signed [CW+1:0] nxt;
   logic [CW-1:0]        word_d;

   assign cur = $signed({2'b00, word});

   always_comb begin
      nxt = cur;
      if (mode == MD_TDC) begin
         if (tdc_vld) nxt = cur + (CW+2)'(tdc_err);
      end else if (bb_up) begin
         nxt = cur + (CW+2)'(1);
      end else begin
         nxt = cur - (CW+2)'(1);
      end
      if (nxt < 0)                            word_d = '0;
      else if (nxt > $signed((CW+2)'(MAXW)))  word_d = CW'(MAXW);
      else                                    word_d = CW'(nxt);
   end

   always_ff @(posedge clk) begin
      if (!rst_n) word <= CW'(MIDW);
      else        word <= word_d;
   end

   // R4
   bb_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (mode != MD_TDC && bb_up && word != CW'(MAXW)) |=> (word == $past(word) + CW'(1)));
   // R5
   no_wrap_top_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (mode != MD_TDC && bb_up && word == CW'(MAXW)) |=> (word == CW'(MAXW)));
   // R5
   no_wrap_bot_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (mode != MD_TDC && !bb_up && word == '0) |=> (word == '0));
endmodule

// File: rtl/dtc_dsm.sv
module dtc_dsm #(
   parameter int FW    = 6,
   parameter int ORDER = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              en,
   input  logic [FW-1:0]     frac,
   output logic signed [2:0] dith
);
   logic [FW-1:0] a1;
   logic [FW-1:0] s1;
   logic          c1;

   assign {c1, s1} = {1'b0, a1} + {1'b0, frac};

   if (ORDER == 1) begin : g_first
      always_ff @(posedge clk) begin
         if (!rst_n || !en) begin
            a1   <= '0;
            dith <= '0;
         end else begin
            a1   <= s1;
            dith <= $signed({2'b00, c1});
         end
      end
   end else if (ORDER == 2) begin : g_second
      logic [FW-1:0] a2;
      logic [FW-1:0] s2;
      logic          c2;
      logic          c2q;

      assign {c2, s2} = {1'b0, a2} + {1'b0, s1};

      always_ff @(posedge clk) begin
         if (!rst_n || !en) begin
            a1   <= '0;
            a2   <= '0;
            c2q  <= 1'b0;
            dith <= '0;
         end else begin
            a1   <= s1;
            a2   <= s2;
            c2q  <= c2;
            dith <= $signed({2'b00, c1}) + $signed({2'b00, c2}) - $signed({2'b00, c2q});
         end
      end

      // R8
      dith_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
         (dith == 3'b111) || (dith == 3'b000) || (dith == 3'b001) || (dith == 3'b010));
   end else begin : g_bad_order
      $error("dtc_dsm: ORDER must be 1 or 2");
   end

   // R6
   dsm_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !en |=> (dith == 3'b000));
endmodule

// File: rtl/dtc_therm.sv
module dtc_therm #(
   parameter int IW = 4
) (
   input  logic [IW-1:0]       int_part,
   input  logic signed [2:0]   dith,
   output logic [2**IW-2:0]    therm
);
   localparam int LW   = IW + 3;
   localparam int TOPL = 2**IW - 1;

   logic signed [LW-1:0] lv_raw;
   logic signed [LW-1:0] lv;

   assign lv_raw = $signed({3'b000, int_part}) + LW'(dith);

   always_comb begin
      if (lv_raw < 0)                          lv = '0;
      else if (lv_raw > $signed(LW'(TOPL)))    lv = LW'(TOPL);
      else                                     lv = lv_raw;
   end

   for (genvar i = 0; i < TOPL; i++) begin : g_cell
      assign therm[i] = (lv > $signed(LW'(i)));
   end
endmodule

// File: rtl/dll_track_ctrl.sv
module dll_track_ctrl
   import dtc_pkg::*;
#(
   parameter int CW        = 10,
   parameter int FW        = 6,
   parameter int EW        = 10,
   parameter int FSW       = 6,
   parameter int N_MIN     = 24,
   parameter int N_MAX     = 47,
   parameter int TDC_CYC   = 10,
   parameter int ALT_RUN   = 4,
   parameter int DSM_ORDER = 2
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic [FSW-1:0]        freq_sel,
   input  logic                  tdc_vld,
   input  logic [EW-1:0]         tdc_err,
   input  logic                  bb_up,
   output logic [CW-1:0]         ctrl_word,
   output logic [2**(CW-FW)-2:0] therm,
   output logic [2:0]            dith_code,
   output logic                  tdc_en,
   output logic [FSW-1:0]        n_div,
   output logic                  locked
);
   localparam int IW = CW - FW;

   if (FW >= CW) begin : g_bad_fw
      $error("dll_track_ctrl: FW must be below CW");
   end
   if (EW > CW + 1) begin : g_bad_ew
      $error("dll_track_ctrl: EW too wide for the word");
   end
   if (N_MIN > N_MAX || N_MAX >= 2**FSW) begin : g_bad_n
      $error("dll_track_ctrl: divide range does not fit");
   end
   if (TDC_CYC < 1 || ALT_RUN < 1) begin : g_bad_cnt
      $error("dll_track_ctrl: counts must be positive");
   end

   trk_mode_t         mode;
   logic              dsm_en;
   logic signed [2:0] dith;

   dtc_mode_seq #(.TDC_CYC(TDC_CYC), .ALT_RUN(ALT_RUN)) u_seq (
      .clk(clk), .rst_n(rst_n), .bb_up(bb_up),
      .mode(mode), .tdc_en(tdc_en), .dsm_en(dsm_en), .lock(locked)
   );

   dtc_word #(.CW(CW), .EW(EW)) u_word (
      .clk(clk), .rst_n(rst_n), .mode(mode), .tdc_vld(tdc_vld),
      .tdc_err($signed(tdc_err)), .bb_up(bb_up), .word(ctrl_word)
   );

   dtc_dsm #(.FW(FW), .ORDER(DSM_ORDER)) u_dsm (
      .clk(clk), .rst_n(rst_n), .en(dsm_en),
      .frac(ctrl_word[FW-1:0]), .dith(dith)
   );

   dtc_therm #(.IW(IW)) u_therm (
      .int_part(ctrl_word[CW-1:FW]), .dith(dith), .therm(therm)
   );

   assign dith_code = dith;

   always_comb begin
      if (freq_sel < FSW'(N_MIN))      n_div = FSW'(N_MIN);
      else if (freq_sel > FSW'(N_MAX)) n_div = FSW'(N_MAX);
      else                             n_div = freq_sel;
   end

   // R9
   therm_shape_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ((therm & (therm + 1'b1)) == '0));
   // R10
   n_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (n_div >= FSW'(N_MIN)) && (n_div <= FSW'(N_MAX)));
   // R3
   tdc_lock_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(tdc_en && locked));
endmodule

// File: tb/tb_dll_track_ctrl.sv
module tb_dll_track_ctrl;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [5:0]  freq_sel = 6'd30;
   logic        tdc_vld = 1'b0;
   logic [9:0]  tdc_err = '0;
   logic        bb_up = 1'b0;
   logic [9:0]  ctrl_word;
   logic [14:0] therm;
   logic [2:0]  dith_code;
   logic        tdc_en;
   logic [5:0]  n_div;
   logic        locked;

   int errors = 0;
   int checks = 0;

   // model state for the dither phase
   int mw, a1, a2, c2p;
   bit model_dsm;

   always #2 clk = ~clk;

   dll_track_ctrl dut (
      .clk(clk), .rst_n(rst_n), .freq_sel(freq_sel), .tdc_vld(tdc_vld),
      .tdc_err(tdc_err), .bb_up(bb_up), .ctrl_word(ctrl_word), .therm(therm),
      .dith_code(dith_code), .tdc_en(tdc_en), .n_div(n_div), .locked(locked)
   );

   // coarse-phase vectors: {tdc_vld, tdc_err, expected word, expected tdc_en}
   localparam int NV = 10;
   localparam logic [21:0] TV [NV] = '{
      {1'b1, 10'd100,  10'd612,  1'b1},
      {1'b0, 10'd500,  10'd612,  1'b1},
      {1'b1, 10'h3CE,  10'd562,  1'b1},
      {1'b1, 10'd511,  10'd1023, 1'b1},
      {1'b1, 10'd5,    10'd1023, 1'b1},
      {1'b1, 10'h200,  10'd511,  1'b1},
      {1'b1, 10'h201,  10'd0,    1'b1},
      {1'b1, 10'h3FD,  10'd0,    1'b1},
      {1'b1, 10'd200,  10'd200,  1'b1},
      {1'b1, 10'd40,   10'd240,  1'b0}
   };

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   function automatic int clamp_lvl(input int v);
      if (v < 0) return 0;
      if (v > 15) return 15;
      return v;
   endfunction

   task automatic edge_step();
      @(posedge clk);
      @(negedge clk);
   endtask

   // one tracking cycle with a full model update and check
   task automatic bb_step(input bit up, input bit check_all);
      int f, s1, c1, s2, c2, d;
      bb_up = up;
      d = 0;
      if (model_dsm) begin
         f  = mw % 64;
         s1 = a1 + f;  c1 = (s1 >= 64) ? 1 : 0;  a1 = s1 % 64;
         s2 = a2 + a1; c2 = (s2 >= 64) ? 1 : 0;  a2 = s2 % 64;
         d  = c1 + c2 - c2p;
         c2p = c2;
      end
      if (up) mw = (mw == 1023) ? 1023 : mw + 1;
      else    mw = (mw == 0) ? 0 : mw - 1;
      edge_step();
      if (check_all) begin
         chk(ctrl_word == 10'(mw), "R4", ctrl_word, mw);
         chk($signed(dith_code) == d, "R8", $signed(dith_code), d);
         chk($countones(therm) == clamp_lvl(mw / 64 + d), "R9", $countones(therm),
             clamp_lvl(mw / 64 + d));
      end
   endtask

   initial begin
      #800000;
      errors++;
      checks++;
      $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      int lock_edge;
      int edges;
      // reset state
      repeat (3) @(negedge clk);
      chk(tdc_en == 1'b1, "R1", tdc_en, 1);
      chk(locked == 1'b0, "R1", locked, 0);
      chk(ctrl_word == 10'd512, "R1", ctrl_word, 512);
      chk(dith_code == 3'd0, "R1", dith_code, 0);
      chk($countones(therm) == 8, "R6", $countones(therm), 8);
      rst_n = 1'b1;
      edges = 0;

      // coarse phase from the vector table
      for (int k = 0; k < NV; k++) begin
         tdc_vld = TV[k][21];
         tdc_err = TV[k][20:11];
         edge_step();
         edges++;
         chk(ctrl_word == TV[k][10:1], "R2", ctrl_word, TV[k][10:1]);
         chk(tdc_en == TV[k][0], "R3", tdc_en, TV[k][0]);
      end

      // tracking with stray converter samples that must be ignored (R3)
      tdc_vld = 1'b1;
      tdc_err = 10'd100;
      mw = 240;
      model_dsm = 1'b0;
      a1 = 0; a2 = 0; c2p = 0;
      lock_edge = -1;
      begin
         bit seq [11] = '{1,1,1,1,1,0,0,1,0,1,0};
         for (int k = 0; k < 11; k++) begin
            bb_step(seq[k], 1'b0);
            edges++;
            chk(ctrl_word == 10'(mw), "R3", ctrl_word, mw);
            chk(dith_code == 3'd0, "R6", dith_code, 0);
            chk($countones(therm) == mw / 64, "R6", $countones(therm), mw / 64);
            if (k < 10) chk(locked == 1'b0, "R7", locked, 0);
            if (locked && lock_edge < 0) lock_edge = edges;
         end
      end
      chk(locked == 1'b1, "R7", locked, 1);
      chk(lock_edge > 0 && lock_edge <= 40, "R7", lock_edge, 21);
      tdc_vld = 1'b0;

      // dither phase with alternating decisions
      model_dsm = 1'b1;
      for (int k = 0; k < 64; k++) bb_step(k % 2 == 0, 1'b1);
      // drive into the top limit with dither running
      for (int k = 0; k < 800; k++) bb_step(1'b1, 1'b1);
      chk(ctrl_word == 10'd1023, "R5", ctrl_word, 1023);
      chk($countones(therm) <= 15, "R9", $countones(therm), 15);
      // and down to the floor
      for (int k = 0; k < 1100; k++) bb_step(1'b0, 1'b1);
      chk(ctrl_word == 10'd0, "R5", ctrl_word, 0);
      chk(locked == 1'b1, "R7", locked, 1);

      // reset in mid-run
      rst_n = 1'b0;
      edge_step();
      chk(tdc_en == 1'b1, "R1", tdc_en, 1);
      chk(locked == 1'b0, "R1", locked, 0);
      chk(ctrl_word == 10'd512, "R1", ctrl_word, 512);
      chk(dith_code == 3'd0, "R1", dith_code, 0);
      rst_n = 1'b1;

      // divide-ratio clamp
      begin
         int fin [6] = '{0, 23, 24, 35, 47, 63};
         int fex [6] = '{24, 24, 24, 35, 47, 47};
         for (int k = 0; k < 6; k++) begin
            freq_sel = 6'(fin[k]);
            #1;
            chk(n_div == 6'(fex[k]), "R10", n_div, fex[k]);
         end
      end

      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule